// File: doc/BRIEF.md
# MII PTP Event Frame Detector

This block sits passively on one MII data path, receiving a 4-bit nibble and a data-valid flag on every MII clock. It finds the preamble and the start-of-frame delimiter. It then puts nibbles together into bytes and skips the twelve bytes of destination and source MAC address. Next it checks whether the two EtherType bytes that follow carry the value 0x88F7, which marks a PTP frame. On a match it raises a pulse that lasts one MII clock.

A toggle handshake carries that pulse into an unrelated system clock domain. There it comes out as a pulse one system clock long. A timestamping or event-counting block can use either pulse to learn that a PTP frame crossed the wire. The block does not parse VLAN tags and does not check the frame checksum.

Top module: `ptp_frame_spotter`

## Requirements
- R1: After a synchronous reset of both domains, `ptp_hit_mii` and `ptp_hit_sys` are low, and they stay low while `mii_dv` is low.
- R2: Nibbles are paired low nibble first into bytes. The EtherType is taken as the high byte 0x88 followed by the low byte 0xF7, so the nibble sequence on the wire is 0x8, 0x8, 0x7, 0xF. Any other value or ordering of these four nibbles (for example 0x0800, or the bytes swapped, or the nibbles swapped within a byte) gives no pulse.
- R3: A frame starts when one or more 0x5 nibbles are followed by a 0xD nibble. A frame whose first valid nibble is not 0x5 is ignored. So is a frame in which a nibble other than 0x5 or 0xD appears before the 0xD; in both cases the block ignores the rest of the frame until `mii_dv` falls.
- R4: Exactly 24 nibbles (12 bytes) after the delimiter are skipped. A 0x88F7 pattern placed 2 nibbles earlier or 2 nibbles later gives no pulse.
- R5: `ptp_hit_mii` is high for exactly one MII clock. That clock is the cycle that follows the rising edge at which the last EtherType nibble (0xF) is sampled with `mii_dv` high.
- R6: If `mii_dv` is low at any point in a frame, the parser returns to idle and produces no pulse for that frame, even if the drop lands on the last EtherType nibble. A new frame may start on the next valid nibble.
- R7: Each frame gives at most one pulse, even when later payload bytes contain 0x88F7.
- R8: Each `ptp_hit_mii` pulse gives exactly one `ptp_hit_sys` pulse, one system clock wide, provided successive pulses are at least four system clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mii_clk | input | 1 | MII nibble clock |
| mii_rst | input | 1 | Synchronous active-high reset, MII domain |
| mii_dv | input | 1 | Nibble valid / frame enable |
| mii_nib | input | 4 | MII data nibble |
| sys_clk | input | 1 | System clock |
| sys_rst | input | 1 | Synchronous active-high reset, system domain |
| ptp_hit_mii | output | 1 | One-MII-clock PTP match pulse |
| ptp_hit_sys | output | 1 | One-system-clock PTP match pulse |

## Verification
Well-formed PTP frames with a long preamble and with a one-nibble preamble should give one pulse each. A second 0x88F7 in the payload shows that only one pulse is made per frame. Frames with EtherType 0x0800, with the bytes swapped or with the nibbles swapped inside a byte tell byte assembly apart from a plain nibble compare. Moving the EtherType two nibbles early or late checks the header count. A missing preamble, a corrupted preamble, a `mii_dv` drop in the middle of the header and a `mii_dv` drop on the final nibble check the return to idle. Back-to-back frames with a single idle nibble show that the parser re-arms, and that each pulse crosses to the system domain as its own pulse.

// File: rtl/ptp_spot_pkg.sv
package ptp_spot_pkg;

    localparam int          NIB_W      = 4;
    localparam int          BYTE_W     = 8;
    localparam logic [15:0] PTP_ETYPE  = 16'h88F7;
    localparam logic [3:0]  PRE_NIB    = 4'h5;
    localparam logic [3:0]  SFD_NIB    = 4'hD;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_PRE,
        PS_HDR,
        PS_TYPE,
        PS_HOLD
    } pstate_e;

    // Byte idx of an EtherType as sent on the wire: 0 = high byte first.
    function automatic logic [7:0] etype_byte(input logic [15:0] et, input logic idx);
        return idx ? et[7:0] : et[15:8];
    endfunction

endpackage

// File: rtl/spot_byte_pack.sv
module spot_byte_pack
    import ptp_spot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              nib_take,
    input  logic [NIB_W-1:0]  nib,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_o
);
    logic             phase;
    logic [NIB_W-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            phase <= 1'b0;
            lo_q  <= '0;
        end else if (nib_take) begin
            phase <= ~phase;
            if (!phase) lo_q <= nib;
        end
    end

    // low nibble arrives first, the second nibble completes the byte
    assign byte_vld = nib_take && phase;
    assign byte_o   = {nib, lo_q};

endmodule

// File: rtl/spot_header_parser.sv
module spot_header_parser
    import ptp_spot_pkg::*;
#(
    parameter int          HDR_BYTES = 12,
    parameter logic [15:0] ETYPE     = PTP_ETYPE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dv,
    input  logic [NIB_W-1:0]  nib,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              pack_clear,
    output logic              nib_take,
    output logic              match_o
);
    localparam int             CNT_W    = $clog2(HDR_BYTES + 1);
    localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_BYTES - 1);

    pstate_e          st, st_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             ok, ok_nx, hit_nx, byte_eq;
    logic             in_frame;

    assign in_frame   = (st == PS_HDR) || (st == PS_TYPE);
    assign nib_take   = dv && in_frame;
    assign pack_clear = !in_frame;
    assign byte_eq    = (byte_in == etype_byte(ETYPE, cnt[0]));

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        ok_nx  = ok;
        hit_nx = 1'b0;
        case (st)
            PS_IDLE: begin
                if (dv) st_nx = (nib == PRE_NIB) ? PS_PRE : PS_HOLD;
            end
            PS_PRE: begin
                if (!dv) begin
                    st_nx = PS_IDLE;
                end else if (nib == SFD_NIB) begin
                    st_nx  = PS_HDR;
                    cnt_nx = '0;
                end else if (nib != PRE_NIB) begin
                    st_nx = PS_HOLD;
                end
            end
            PS_HDR: begin
                if (!dv) begin
                    st_nx = PS_IDLE;
                end else if (byte_vld) begin
                    if (cnt == HDR_LAST) begin
                        st_nx  = PS_TYPE;
                        cnt_nx = '0;
                        ok_nx  = 1'b1;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
            end
            PS_TYPE: begin
                if (!dv) begin
                    st_nx = PS_IDLE;
                end else if (byte_vld) begin
                    if (cnt[0]) begin
                        st_nx  = PS_HOLD;
                        hit_nx = ok && byte_eq;
                    end else begin
                        ok_nx  = byte_eq;
                        cnt_nx = cnt + 1'b1;
                    end
                end
            end
            PS_HOLD: begin
                if (!dv) st_nx = PS_IDLE;
            end
            default: st_nx = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= PS_IDLE;
            cnt     <= '0;
            ok      <= 1'b0;
            match_o <= 1'b0;
        end else begin
            st      <= st_nx;
            cnt     <= cnt_nx;
            ok      <= ok_nx;
            match_o <= hit_nx;
        end
    end

    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (rst)
        match_o |=> !match_o);

    assert_no_pulse_after_drop_R6: assert property (@(posedge clk) disable iff (rst)
        !dv |=> !match_o);

    assert_one_per_frame_R7: assert property (@(posedge clk) disable iff (rst)
        match_o |-> (st == PS_HOLD));

    assert_header_length_R4: assert property (@(posedge clk) disable iff (rst)
        (st == PS_TYPE && $past(st) == PS_HDR) |-> ($past(cnt) == HDR_LAST));

endmodule

// File: rtl/spot_pulse_xfer.sv
module spot_pulse_xfer #(
    parameter int SYNC_STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst,
    input  logic pulse_i,
    input  logic dst_clk,
    input  logic dst_rst,
    output logic pulse_o
);
    logic                   tgl;
    logic [SYNC_STAGES-1:0] chain;
    logic                   hist;

    always_ff @(posedge src_clk) begin
        if (src_rst) tgl <= 1'b0;
        else         tgl <= tgl ^ pulse_i;
    end

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            always_ff @(posedge dst_clk) begin
                if (dst_rst) chain[i] <= 1'b0;
                else if (i == 0) chain[i] <= tgl;
                else chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    always_ff @(posedge dst_clk) begin
        if (dst_rst) hist <= 1'b0;
        else         hist <= chain[SYNC_STAGES-1];
    end

    assign pulse_o = chain[SYNC_STAGES-1] ^ hist;

    // valid when source pulses are spaced as the brief requires
    assert_sys_single_R8: assert property (@(posedge dst_clk) disable iff (dst_rst)
        pulse_o |=> !pulse_o);

endmodule

// File: rtl/ptp_frame_spotter.sv
module ptp_frame_spotter
    import ptp_spot_pkg::*;
#(
    parameter int          HDR_BYTES   = 12,
    parameter logic [15:0] ETYPE       = PTP_ETYPE,
    parameter int          SYNC_STAGES = 2
) (
    input  logic             mii_clk,
    input  logic             mii_rst,
    input  logic             mii_dv,
    input  logic [NIB_W-1:0] mii_nib,
    input  logic             sys_clk,
    input  logic             sys_rst,
    output logic             ptp_hit_mii,
    output logic             ptp_hit_sys
);
    logic              pack_clear, nib_take, byte_vld;
    logic [BYTE_W-1:0] byte_w;

    spot_byte_pack u_pack (
        .clk      (mii_clk),
        .rst      (mii_rst),
        .clear    (pack_clear),
        .nib_take (nib_take),
        .nib      (mii_nib),
        .byte_vld (byte_vld),
        .byte_o   (byte_w)
    );

    spot_header_parser #(
        .HDR_BYTES (HDR_BYTES),
        .ETYPE     (ETYPE)
    ) u_parse (
        .clk        (mii_clk),
        .rst        (mii_rst),
        .dv         (mii_dv),
        .nib        (mii_nib),
        .byte_vld   (byte_vld),
        .byte_in    (byte_w),
        .pack_clear (pack_clear),
        .nib_take   (nib_take),
        .match_o    (ptp_hit_mii)
    );

    spot_pulse_xfer #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_xfer (
        .src_clk (mii_clk),
        .src_rst (mii_rst),
        .pulse_i (ptp_hit_mii),
        .dst_clk (sys_clk),
        .dst_rst (sys_rst),
        .pulse_o (ptp_hit_sys)
    );

    assert_idle_quiet_R1: assert property (@(posedge mii_clk) disable iff (mii_rst)
        !mii_dv |=> !ptp_hit_mii);

endmodule

// File: tb/tb_ptp_frame_spotter.sv
module tb_ptp_frame_spotter;

    logic       mii_clk = 0, sys_clk = 0;
    logic       mii_rst = 1, sys_rst = 1;
    logic       mii_dv  = 0;
    logic [3:0] mii_nib = 0;
    logic       ptp_hit_mii, ptp_hit_sys;

    int checks = 0, errors = 0;
    int mii_pulses = 0, sys_pulses = 0;
    bit done = 0;

    always #5 mii_clk = ~mii_clk;   // 100 MHz
    always #7 sys_clk = ~sys_clk;

    ptp_frame_spotter dut (
        .mii_clk(mii_clk), .mii_rst(mii_rst), .mii_dv(mii_dv), .mii_nib(mii_nib),
        .sys_clk(sys_clk), .sys_rst(sys_rst),
        .ptp_hit_mii(ptp_hit_mii), .ptp_hit_sys(ptp_hit_sys)
    );

    // ---------------- behavioural reference ----------------
    logic [3:0] seen[$];
    bit         exp_hit = 0;

    function automatic bit ptp_expected(logic [3:0] q[$]);
        int p = 0;
        while (p < q.size() && q[p] == 4'h5) p++;
        if (p == 0 || p >= q.size() || q[p] != 4'hD) return 0;
        if (q.size() != p + 29) return 0;
        return q[p+25] == 4'h8 && q[p+26] == 4'h8 && q[p+27] == 4'h7 && q[p+28] == 4'hF;
    endfunction

    always @(posedge mii_clk) begin
        if (mii_rst || !mii_dv) begin
            seen.delete();
            exp_hit = 0;
        end else begin
            seen.push_back(mii_nib);
            exp_hit = ptp_expected(seen);
        end
    end

    always @(negedge mii_clk) begin
        checks++;
        if (ptp_hit_mii !== exp_hit) begin
            errors++;
            $display("FAIL R5 per-cycle ptp_hit_mii actual %0b expected %0b at %0t",
                     ptp_hit_mii, exp_hit, $time);
        end
        if (ptp_hit_mii === 1'b1) mii_pulses++;
    end

    bit sys_prev = 0;
    always @(negedge sys_clk) begin
        if (ptp_hit_sys === 1'b1) begin
            sys_pulses++;
            checks++;
            if (sys_prev) begin
                errors++;
                $display("FAIL R8 ptp_hit_sys wider than one cycle actual 1 expected 0");
            end
        end
        sys_prev = (ptp_hit_sys === 1'b1);
    end

    // ---------------- stimulus helpers ----------------
    logic [3:0] fq[$];

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic add_pre(input int n);
        for (int i = 0; i < n; i++) fq.push_back(4'h5);
        fq.push_back(4'hD);
    endtask

    task automatic add_hdr(input int n);
        for (int i = 0; i < n; i++) fq.push_back(4'((i * 7 + 3) & 15));
    endtask

    // EtherType sent high byte first, each byte low nibble first
    task automatic add_type(input logic [15:0] et);
        fq.push_back(et[11:8]); fq.push_back(et[15:12]);
        fq.push_back(et[3:0]);  fq.push_back(et[7:4]);
    endtask

    task automatic add_nibs(input logic [15:0] four);
        fq.push_back(four[15:12]); fq.push_back(four[11:8]);
        fq.push_back(four[7:4]);   fq.push_back(four[3:0]);
    endtask

    task automatic play(input int gap);
        foreach (fq[i]) begin
            @(negedge mii_clk);
            mii_dv  = 1;
            mii_nib = fq[i];
        end
        fq.delete();
        for (int i = 0; i < gap; i++) begin
            @(negedge mii_clk);
            mii_dv  = 0;
            mii_nib = 0;
        end
    endtask

    int m0, s0;
    task automatic mark();
        m0 = mii_pulses; s0 = sys_pulses;
    endtask

    task automatic expect_pulses(input string tag, input int n);
        repeat (12) @(negedge mii_clk);
        check(mii_pulses - m0 == n, {tag, " mii pulses"}, mii_pulses - m0, n);
        check(sys_pulses - s0 == n, {"R8 ", tag, " sys pulses"}, sys_pulses - s0, n);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- scenarios ----------------
    initial begin
        repeat (4) @(negedge sys_clk);
        @(negedge mii_clk); mii_rst = 0;
        @(negedge sys_clk); sys_rst = 0;
        repeat (3) @(negedge mii_clk);
        check(ptp_hit_mii == 0 && ptp_hit_sys == 0, "R1 reset outputs", ptp_hit_mii, 0);

        // R2 R5 R7: good frame, payload repeats the pattern
        mark(); add_pre(15); add_hdr(24); add_type(16'h88F7); add_type(16'h88F7);
        add_hdr(10); add_type(16'h88F7); play(4);
        expect_pulses("R7 single pulse with repeats", 1);

        // R3: shortest preamble
        mark(); add_pre(1); add_hdr(24); add_type(16'h88F7); add_hdr(6); play(4);
        expect_pulses("R3 one-nibble preamble", 1);

        // R2: other EtherType values and orders
        mark(); add_pre(15); add_hdr(24); add_type(16'h0800); add_hdr(6); play(4);
        expect_pulses("R2 ethertype 0x0800", 0);
        mark(); add_pre(15); add_hdr(24); add_type(16'hF788); add_hdr(6); play(4);
        expect_pulses("R2 bytes swapped", 0);
        mark(); add_pre(15); add_hdr(24); add_nibs(16'h88F7); add_hdr(6); play(4);
        expect_pulses("R2 nibbles swapped", 0);

        // R4: offset wrong by one byte either way
        mark(); add_pre(15); add_hdr(22); add_type(16'h88F7); add_hdr(6); play(4);
        expect_pulses("R4 early ethertype", 0);
        mark(); add_pre(15); add_hdr(26); add_type(16'h88F7); add_hdr(6); play(4);
        expect_pulses("R4 late ethertype", 0);

        // R3: no preamble, corrupted preamble
        mark(); fq.push_back(4'hD); add_hdr(24); add_type(16'h88F7); play(4);
        expect_pulses("R3 missing preamble", 0);
        mark(); fq.push_back(4'h5); fq.push_back(4'h5); fq.push_back(4'h3);
        add_pre(3); add_hdr(24); add_type(16'h88F7); play(4);
        expect_pulses("R3 corrupted preamble", 0);

        // R6: drop mid header then a good frame after one idle nibble
        mark(); add_pre(15); add_hdr(10); play(1);
        add_pre(15); add_hdr(24); add_type(16'h88F7); play(4);
        expect_pulses("R6 drop then resume", 1);

        // R6: drop exactly on final EtherType nibble
        mark(); add_pre(15); add_hdr(24); fq.push_back(4'h8); fq.push_back(4'h8);
        fq.push_back(4'h7); play(4);
        expect_pulses("R6 drop on last nibble", 0);

        // R8: back-to-back frames, one idle nibble apart
        mark(); add_pre(7); add_hdr(24); add_type(16'h88F7); play(1);
        add_pre(7); add_hdr(24); add_type(16'h88F7); play(4);
        expect_pulses("R8 back-to-back", 2);

        check(ptp_hit_mii == 0 && ptp_hit_sys == 0, "R1 quiet while idle", ptp_hit_mii, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule